// File: doc/BRIEF.md
# Sector Address Header Emitter

This block produces the byte-level sequence of a sector address header for a disk write path. A single `start` pulse captures track, sector, side and a format byte, and the block then offers a stream of items on a valid/ready port to a downstream encoder. Each item carries a kind code: a self-sync nibble, a raw mark byte written without translation, or a data byte that the encoder must translate to a disk code word.

The stream has a fixed order. It begins with a run of self-sync nibbles whose length comes from `sync_len`, or 1536 nibbles (six passes of 256) when `sync_track` asks for a full sync track. Three start marks follow. The body comes next: track, sector, side, format byte and an XOR checksum. Two end marks close the header, and a turn-off nibble ends the stream. When bit 6 of the track number is set, bit 0 of the side byte is forced to 1, and the checksum covers the adjusted side.

The downstream side is expected to take one item per nibble time. Once the first item has been accepted, a stall longer than that window is an underrun. The header is then abandoned and an error is flagged. The state machine moves through ST_IDLE, ST_SYNC, ST_SMARK, ST_BODY, ST_EMARK and ST_TOFF. ST_IDLE goes to ST_SYNC on start, or straight to ST_SMARK when the sync count is zero. Each of ST_SYNC, ST_SMARK, ST_BODY and ST_EMARK advances to the next state on the handshake of its last item. ST_TOFF returns to ST_IDLE on its handshake. Any busy state returns to ST_IDLE on an underrun.

Top module: `hdr_addr_writer`

## Requirements
- R1: After reset `nib_valid`, `done` and `hdr_err` are all 0, and they stay 0 until a start is given.
- R2: `start` in ST_IDLE captures track, sector, side, format, `sync_len` and `sync_track`. The first item is valid in the cycle after. A `start` or an input change while busy has no effect on the stream.
- R3: With `sync_track` low, the stream opens with exactly `sync_len` items of data 0xFF and kind 0 (self-sync). If `sync_len` is 0, no sync items are sent.
- R4: With `sync_track` high, exactly 1536 sync items are sent, whatever the value of `sync_len`.
- R5: After the sync items come the start marks 0xD5, 0xAA, 0x96 in that order, each with kind 1 (raw mark).
- R6: The body items follow in the order track, sector, side, format, checksum, each with kind 2 (data).
- R7: If track bit 6 is 1, the side item has bit 0 set to 1. Its other bits are the captured side.
- R8: The checksum item equals track XOR adjusted side XOR sector XOR format.
- R9: After the checksum come the end marks 0xDE and 0xAA, then the turn-off item 0xFF, all with kind 1.
- R10: `done` is high for exactly one cycle, in the cycle after the turn-off item is accepted, and `nib_valid` is low in that cycle.
- R11: Once at least one item has been accepted, if `nib_ready` stays low for NIB_CYCLES (default 8) consecutive cycles while `nib_valid` is high, the stream is abandoned. In the next cycle `nib_valid` is low and `hdr_err` is high for one cycle. A stall before the first acceptance never aborts.
- R12: While `nib_valid` is high and `nib_ready` is low, `nib_data` and `nib_kind` hold their values until the item is accepted or the stream is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one header (sampled in ST_IDLE) |
| track | input | 8 | Track number |
| sector | input | 8 | Sector number |
| side | input | 8 | Side byte |
| fmt | input | 8 | Format byte |
| sync_len | input | 11 | Number of sync nibbles in normal mode |
| sync_track | input | 1 | Select the 1536-nibble sync-track preamble |
| nib_valid | output | 1 | Item offered |
| nib_ready | input | 1 | Downstream accepts the item |
| nib_data | output | 8 | Item byte |
| nib_kind | output | 2 | 0 sync, 1 raw mark, 2 data byte |
| done | output | 1 | One-cycle pulse when the header completes |
| hdr_err | output | 1 | One-cycle pulse when an underrun abandons the header |

## Verification
A wrong state or index shows at the ports as soon as the bad item is offered. It appears as a misplaced mark, a body field out of order, or a wrong kind code, and it is visible in the cycle after the faulty handshake. An error in the captured fields or in the checksum shows on the body items and the checksum item of the same header. A wrong stall counter shows as `hdr_err` firing one cycle early or late, or firing during the initial stall that must be tolerated. The bench follows every item and every cycle with a queue-based model, so each of these faults is caught in the first cycle where it differs.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    typedef enum logic [1:0] {
        KIND_SYNC = 2'd0,
        KIND_MARK = 2'd1,
        KIND_DATA = 2'd2
    } nib_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SMARK,
        ST_BODY,
        ST_EMARK,
        ST_TOFF
    } hdr_state_t;

    localparam int START_MARKS = 3;
    localparam int BODY_BYTES  = 5;
    localparam int END_MARKS   = 2;
endpackage

// File: rtl/hdr_fsm.sv
module hdr_fsm
    import hdr_pkg::*;
#(
    parameter int SYNC_W        = 11,
    parameter int SYNC_TRK_LEN  = 1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sync_track,
    input  logic [SYNC_W-1:0] sync_len,
    input  logic              hs,
    input  logic              underrun,
    output hdr_state_t        state,
    output logic [SYNC_W-1:0] idx,
    output logic              busy,
    output logic              load,
    output logic              done,
    output logic              err
);
    localparam logic [SYNC_W-1:0] ONE     = SYNC_W'(1);
    localparam logic [SYNC_W-1:0] LAST_SM = SYNC_W'(START_MARKS - 1);
    localparam logic [SYNC_W-1:0] LAST_BD = SYNC_W'(BODY_BYTES - 1);
    localparam logic [SYNC_W-1:0] LAST_EM = SYNC_W'(END_MARKS - 1);
    localparam logic [SYNC_W-1:0] TRK_LEN = SYNC_W'(SYNC_TRK_LEN);

    hdr_state_t        nxt;
    logic [SYNC_W-1:0] nidx, sync_tot, ntot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            sync_tot <= '0;
        end else begin
            state    <= nxt;
            idx      <= nidx;
            sync_tot <= ntot;
        end
    end

    always_comb begin
        nxt  = state;
        nidx = idx;
        ntot = sync_tot;
        load = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                load = 1'b1;
                nidx = '0;
                ntot = sync_track ? TRK_LEN : sync_len;
                nxt  = (ntot == '0) ? ST_SMARK : ST_SYNC;
            end
            ST_SYNC: if (hs) begin
                if (idx == sync_tot - ONE) begin nxt = ST_SMARK; nidx = '0; end
                else nidx = idx + ONE;
            end
            ST_SMARK: if (hs) begin
                if (idx == LAST_SM) begin nxt = ST_BODY; nidx = '0; end
                else nidx = idx + ONE;
            end
            ST_BODY: if (hs) begin
                if (idx == LAST_BD) begin nxt = ST_EMARK; nidx = '0; end
                else nidx = idx + ONE;
            end
            ST_EMARK: if (hs) begin
                if (idx == LAST_EM) begin nxt = ST_TOFF; nidx = '0; end
                else nidx = idx + ONE;
            end
            ST_TOFF: if (hs) begin
                nxt  = ST_IDLE;
                nidx = '0;
            end
            default: nxt = ST_IDLE;
        endcase
        if (state != ST_IDLE && underrun) begin
            nxt  = ST_IDLE;
            nidx = '0;
        end
    end

    always_comb busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= (state == ST_TOFF) && hs;
            err  <= busy && underrun;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: rtl/hdr_body.sv
module hdr_body #(
    parameter int W            = 8,
    parameter int TRK_FLAG_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] track,
    input  logic [W-1:0] sector,
    input  logic [W-1:0] side,
    input  logic [W-1:0] fmt,
    input  logic [2:0]   sel,
    output logic [W-1:0] body_byte
);
    logic [W-1:0] r_trk, r_sec, r_side, r_fmt, csum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_trk  <= '0;
            r_sec  <= '0;
            r_side <= '0;
            r_fmt  <= '0;
        end else if (load) begin
            r_trk  <= track;
            r_sec  <= sector;
            r_side <= side | {{(W-1){1'b0}}, track[TRK_FLAG_BIT]};
            r_fmt  <= fmt;
        end
    end

    always_comb csum = r_trk ^ r_sec ^ r_side ^ r_fmt;

    always_comb begin
        unique case (sel)
            3'd0:    body_byte = r_trk;
            3'd1:    body_byte = r_sec;
            3'd2:    body_byte = r_side;
            3'd3:    body_byte = r_fmt;
            default: body_byte = csum;
        endcase
    end

    // R7
    side_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && track[TRK_FLAG_BIT]) |=> r_side[0]);
endmodule

// File: rtl/hdr_underrun.sv
module hdr_underrun #(
    parameter int NIB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic valid,
    input  logic ready,
    output logic underrun
);
    localparam int CW = $clog2(NIB_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(NIB_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (valid && ready) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (valid && armed && cnt != LIMIT) begin
            cnt <= cnt + CW'(1);
        end
    end

    always_comb underrun = armed && valid && !ready && (cnt == LIMIT);

    // R11
    underrun_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (valid && !ready));
endmodule

// File: rtl/hdr_addr_writer.sv
module hdr_addr_writer
    import hdr_pkg::*;
#(
    parameter int          SYNC_W       = 11,
    parameter int          NIB_CYCLES   = 8,
    parameter int          SYNC_TRK_LEN = 1536,
    parameter logic [7:0]  SYNC_BYTE    = 8'hFF,
    parameter logic [7:0]  SMARK0       = 8'hD5,
    parameter logic [7:0]  SMARK1       = 8'hAA,
    parameter logic [7:0]  SMARK2       = 8'h96,
    parameter logic [7:0]  EMARK0       = 8'hDE,
    parameter logic [7:0]  EMARK1       = 8'hAA,
    parameter logic [7:0]  TURNOFF      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        track,
    input  logic [7:0]        sector,
    input  logic [7:0]        side,
    input  logic [7:0]        fmt,
    input  logic [SYNC_W-1:0] sync_len,
    input  logic              sync_track,
    output logic              nib_valid,
    input  logic              nib_ready,
    output logic [7:0]        nib_data,
    output logic [1:0]        nib_kind,
    output logic              done,
    output logic              hdr_err
);
    hdr_state_t        state;
    logic [SYNC_W-1:0] idx;
    logic              busy, load, hs, underrun;
    logic [7:0]        body_byte;

    always_comb hs = busy && nib_ready;

    hdr_fsm #(.SYNC_W(SYNC_W), .SYNC_TRK_LEN(SYNC_TRK_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .sync_track(sync_track),
        .sync_len(sync_len), .hs(hs), .underrun(underrun), .state(state),
        .idx(idx), .busy(busy), .load(load), .done(done), .err(hdr_err)
    );

    hdr_body #(.W(8), .TRK_FLAG_BIT(6)) u_body (
        .clk(clk), .rst_n(rst_n), .load(load), .track(track), .sector(sector),
        .side(side), .fmt(fmt), .sel(idx[2:0]), .body_byte(body_byte)
    );

    hdr_underrun #(.NIB_CYCLES(NIB_CYCLES)) u_urun (
        .clk(clk), .rst_n(rst_n), .load(load), .valid(busy),
        .ready(nib_ready), .underrun(underrun)
    );

    always_comb begin
        nib_valid = busy;
        nib_data  = 8'h00;
        nib_kind  = KIND_SYNC;
        unique case (state)
            ST_IDLE:  begin nib_data = 8'h00;     nib_kind = KIND_SYNC; end
            ST_SYNC:  begin nib_data = SYNC_BYTE; nib_kind = KIND_SYNC; end
            ST_SMARK: begin
                nib_kind = KIND_MARK;
                nib_data = (idx[1:0] == 2'd0) ? SMARK0 :
                           (idx[1:0] == 2'd1) ? SMARK1 : SMARK2;
            end
            ST_BODY:  begin nib_data = body_byte; nib_kind = KIND_DATA; end
            ST_EMARK: begin
                nib_kind = KIND_MARK;
                nib_data = idx[0] ? EMARK1 : EMARK0;
            end
            ST_TOFF:  begin nib_data = TURNOFF;   nib_kind = KIND_MARK; end
            default:  begin nib_data = 8'h00;     nib_kind = KIND_SYNC; end
        endcase
    end

    // R12
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_valid && !nib_ready && !underrun) |=>
            (nib_valid && $stable(nib_data) && $stable(nib_kind)));

    // R11
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !nib_valid);

    // R9
    done_after_toff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(nib_kind == KIND_MARK && nib_data == TURNOFF && nib_ready));

    // R6
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid |-> (nib_kind != 2'd3));
endmodule

// File: tb/test_hdr_addr_writer.sv
module test_hdr_addr_writer;
    localparam int NIB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  track = '0, sector = '0, side = '0, fmt = '0;
    logic [10:0] sync_len = '0;
    logic        sync_track = 1'b0;
    logic        nib_ready = 1'b1;
    logic        nib_valid, done, hdr_err;
    logic [7:0]  nib_data;
    logic [1:0]  nib_kind;

    always #10 clk = ~clk;

    hdr_addr_writer i_hdr_addr_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .track(track), .sector(sector),
        .side(side), .fmt(fmt), .sync_len(sync_len), .sync_track(sync_track),
        .nib_valid(nib_valid), .nib_ready(nib_ready), .nib_data(nib_data),
        .nib_kind(nib_kind), .done(done), .hdr_err(hdr_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rmode = 0;

    logic [1:0] qk[$];
    logic [7:0] qd[$];
    int         qt[$];
    bit m_busy = 0, m_done = 0, m_err = 0, m_armed = 0;
    int m_wait = 0;
    bit p_valid = 0, p_ready = 0;
    logic [7:0] p_data = '0;
    logic [1:0] p_kind = '0;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; default: return "R12";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] d, input int t);
        qk.push_back(k); qd.push_back(d); qt.push_back(t);
    endtask

    task automatic build();
        int n;
        logic [7:0] sd;
        n  = sync_track ? 1536 : int'(sync_len);
        sd = track[6] ? (side | 8'h01) : side;
        for (int i = 0; i < n; i++) push(2'd0, 8'hFF, sync_track ? 4 : 3);
        push(2'd1, 8'hD5, 5); push(2'd1, 8'hAA, 5); push(2'd1, 8'h96, 5);
        push(2'd2, track, 6); push(2'd2, sector, 6);
        push(2'd2, sd, 7);    push(2'd2, fmt, 6);
        push(2'd2, track ^ sector ^ sd ^ fmt, 8);
        push(2'd1, 8'hDE, 9); push(2'd1, 8'hAA, 9); push(2'd1, 8'hFF, 9);
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        p_valid = nib_valid; p_ready = nib_ready; p_data = nib_data; p_kind = nib_kind;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_armed = 0; m_wait = 0;
            qk.delete(); qd.delete(); qt.delete();
        end else begin
            m_done = 0; m_err = 0;
            if (m_busy) begin
                if (nib_ready) begin
                    void'(qk.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
                    m_armed = 1; m_wait = 0;
                    if (qk.size() == 0) begin m_busy = 0; m_done = 1; end
                end else if (m_armed) begin
                    m_wait++;
                    if (m_wait == NIB) begin
                        m_busy = 0; m_err = 1;
                        qk.delete(); qd.delete(); qt.delete();
                    end
                end
            end else if (start) begin
                build();
                m_busy = 1; m_armed = 0; m_wait = 0;
            end
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(nib_valid == m_busy, "R2", "valid", nib_valid, m_busy);
            if (m_busy && nib_valid) begin
                chk(nib_data == qd[0], tag_name(qt[0]), "data", nib_data, qd[0]);
                chk(nib_kind == qk[0], tag_name(qt[0]), "kind", nib_kind, qk[0]);
            end
            chk(done == m_done, "R10", "done", done, m_done);
            chk(hdr_err == m_err, "R11", "hdr_err", hdr_err, m_err);
            if (p_valid && !p_ready && nib_valid) begin
                chk(nib_data == p_data && nib_kind == p_kind, "R12", "hold",
                    {nib_kind, nib_data}, {p_kind, p_data});
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        case (rmode)
            0: nib_ready <= 1'b1;
            1: nib_ready <= ((cyc % 5) != 2) && ((cyc % 7) != 3);
            default: nib_ready <= 1'b0;
        endcase
    end

    task automatic kick(input logic [7:0] t, input logic [7:0] s, input logic [7:0] sd,
                        input logic [7:0] f, input int slen, input bit strk);
        @(posedge clk); #1;
        track = t; sector = s; side = sd; fmt = f;
        sync_len = 11'(slen); sync_track = strk; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: quiet after reset
        chk(nib_valid == 1'b0, "R1", "valid after reset", nib_valid, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(hdr_err == 1'b0, "R1", "err after reset", hdr_err, 0);

        // R3 R5 R6 R8 R9: plain header, ready always
        rmode = 0;
        kick(8'h12, 8'h03, 8'h00, 8'h22, 5, 1'b0);
        wait_idle();

        // R7: track bit 6 set, stalls from downstream
        @(posedge clk); #1 rmode = 1;
        kick(8'h45, 8'h0A, 8'h00, 8'h02, 6, 1'b0);
        wait_idle();
        kick(8'h7F, 8'hFF, 8'h81, 8'hC3, 2, 1'b0);
        wait_idle();

        // R3: zero sync count
        kick(8'h01, 8'h02, 8'h01, 8'h00, 0, 1'b0);
        wait_idle();

        // R4: sync-track mode overrides sync_len
        @(posedge clk); #1 rmode = 0;
        kick(8'h00, 8'h00, 8'h00, 8'h22, 3, 1'b1);
        wait_idle();

        // R2: start and new fields while busy are ignored
        @(posedge clk); #1 rmode = 1;
        kick(8'h21, 8'h05, 8'h00, 8'h01, 10, 1'b0);
        repeat (4) @(posedge clk);
        kick(8'h99, 8'h77, 8'h66, 8'h55, 1, 1'b0);
        track = 8'hEE; sector = 8'hDD;
        wait_idle();
        @(negedge clk);
        chk(!nib_valid && !m_busy, "R2", "no second header", nib_valid, 0);

        // R11: underrun in the body
        @(posedge clk); #1 rmode = 0;
        kick(8'h33, 8'h04, 8'h00, 8'h22, 4, 1'b0);
        while (qk.size() > 6) @(posedge clk);
        #1 rmode = 2;
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(!nib_valid, "R11", "valid after underrun", nib_valid, 0);
        @(posedge clk); #1 rmode = 0;
        repeat (3) @(posedge clk);

        // R11: initial stall before first acceptance must not abort
        #1 rmode = 2;
        kick(8'h10, 8'h01, 8'h00, 8'h22, 2, 1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(nib_valid == 1'b1, "R11", "valid during initial stall", nib_valid, 1);
        @(posedge clk); #1 rmode = 0;
        wait_idle();

        // header after an abort runs normally
        kick(8'h4C, 8'h09, 8'h00, 8'h22, 3, 1'b0);
        wait_idle();

        finish_run();
    end
endmodule